// File: doc/BRIEF.md
# Reset Entry and Single-Step Trap Controller

This block holds the control state of a 16-bit processor core that deals with coming out of reset and with trapping after single instructions. An active-low reset input is sampled on the clock. While it is low, every architectural register it owns loads a fixed start value and execution stays disabled. Once the input is released, a start-up counter runs for a set number of clocks before the execution-enable output rises. That output gates instruction fetch and bus activity in the rest of the core. The first fetch goes to segment FFFFh, offset 0000h, which is physical address FFFF0h.

Single stepping is governed by a trap-flag bit in the flag word. The core reports each retired instruction with a strobe. An IRET is reported on its own strobe, together with the flag word it pops. If the trap flag was set when an instruction began, its retirement raises a trap request with vector 1. The request holds until the core acknowledges it, and the acknowledge clears the trap flag. An IRET that pops a word with the trap flag set therefore lets exactly one more instruction run before the next trap.

Top module: `rst_step_ctrl`

## Requirements
- R1: While `rst_n` is sampled low, the edge drives `exec_en_o` and `trap_req_o` to 0, and strobes on `retire_i`, `iret_i` and `inta_i` have no effect.
- R2: A clock edge with `rst_n` low loads the flag word with F002h, the instruction pointer with 0000h, the code segment with FFFFh, and the data, extra and stack segments with 0000h.
- R3: A clock edge with `rst_n` low loads the peripheral base register with 20FFh and the upper-memory select register with FFFBh.
- R4: When `exec_en_o` rises, `fetch_addr_o` equals FFFF0h, which is the code segment times 16 plus the instruction pointer.
- R5: `exec_en_o` rises at exactly the DELAY_CYC-th rising edge at which `rst_n` is sampled high. It then stays high until `rst_n` is sampled low again.
- R6: `retire_i` and `iret_i` are ignored while `exec_en_o` is low or while `trap_req_o` is high. An ignored strobe leaves the flag word and `trap_req_o` unchanged.
- R7: An accepted retire or IRET strobe, taken while the trap flag (bit 8 of the flag word) is 1, sets `trap_req_o` at that edge. While the request is high, `trap_vec_o` is 1. Otherwise `trap_vec_o` is 0.
- R8: `trap_req_o` stays high until `inta_i` is sampled high. That edge clears `trap_req_o` and flag bit 8 and leaves the other flag bits unchanged. `inta_i` with no request pending changes nothing.
- R9: An accepted IRET loads the flag word with `iret_flags_i`. An IRET that sets bit 8 from 0 does not trap itself. The next accepted instruction does.
- R10: An accepted strobe taken while flag bit 8 is 0 leaves `trap_req_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low processor reset, sampled synchronously |
| retire_i | input | 1 | One-cycle strobe: an ordinary instruction retired |
| iret_i | input | 1 | One-cycle strobe: an IRET retired |
| iret_flags_i | input | 16 | Flag word popped by the IRET |
| inta_i | input | 1 | Interrupt-acknowledge pulse for the trap request |
| exec_en_o | output | 1 | Execution/bus enable |
| flags_o | output | 16 | Flag word; bit 8 is the trap flag |
| ip_o | output | 16 | Instruction pointer |
| cs_o | output | 16 | Code segment |
| ds_o | output | 16 | Data segment |
| es_o | output | 16 | Extra segment |
| ss_o | output | 16 | Stack segment |
| pbase_o | output | 16 | Peripheral base register |
| umem_o | output | 16 | Upper-memory select register |
| fetch_addr_o | output | 20 | Physical start-fetch address |
| trap_req_o | output | 1 | Single-step trap request |
| trap_vec_o | output | 8 | Trap vector number |

## Verification
The bench builds the block with DELAY_CYC set to 5 rather than the default. A window that is not the default shows that the counter follows the parameter and does not use a fixed count. Because the window is short, the bench can check `exec_en_o` at every edge of it. It can also go through several full reset and start-up cycles, including one where reset arrives while a trap is pending. Strobes are driven during the window and while a request is outstanding, so the cases where strobes are ignored are exercised next to the stepping sequences.

// File: rtl/rst_step_pkg.sv
package rst_step_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 20;
  localparam int VEC_W  = 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] paddr_t;
  typedef logic [VEC_W-1:0]  vec_t;

  // Start values of the architectural state
  localparam word_t FLAGS_INIT = 16'hF002;
  localparam word_t IP_INIT    = 16'h0000;
  localparam word_t CS_INIT    = 16'hFFFF;
  localparam word_t DS_INIT    = 16'h0000;
  localparam word_t ES_INIT    = 16'h0000;
  localparam word_t SS_INIT    = 16'h0000;
  localparam word_t PBASE_INIT = 16'h20FF;
  localparam word_t UMEM_INIT  = 16'hFFFB;

  // Trap flag position and the vector used for single stepping
  localparam int   TF_BIT   = 8;
  localparam vec_t STEP_VEC = 8'd1;

  typedef struct packed {
    word_t ip;
    word_t cs;
    word_t ds;
    word_t es;
    word_t ss;
    word_t pbase;
    word_t umem;
  } arch_regs_t;

  function automatic paddr_t phys_addr(input word_t seg, input word_t ofs);
    return {seg, 4'h0} + {4'h0, ofs};
  endfunction
endpackage

// File: rtl/rst_step_seq.sv
// Start-up sequencer: execution enable rises after DELAY_CYC clocks out of reset.
module rst_step_seq #(
  parameter int DELAY_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic exec_en
);
  localparam int CNT_W = (DELAY_CYC < 1) ? 1 : $clog2(DELAY_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      exec_en <= 1'b0;
    end else if (!exec_en) begin
      if (cnt_q == LAST) exec_en <= 1'b1;
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rst_step_regs.sv
// Architectural registers that take fixed values on reset, and the start-fetch address.
module rst_step_regs
  import rst_step_pkg::*;
#(
  parameter word_t IP_RST    = IP_INIT,
  parameter word_t CS_RST    = CS_INIT,
  parameter word_t DS_RST    = DS_INIT,
  parameter word_t ES_RST    = ES_INIT,
  parameter word_t SS_RST    = SS_INIT,
  parameter word_t PBASE_RST = PBASE_INIT,
  parameter word_t UMEM_RST  = UMEM_INIT
) (
  input  logic       clk,
  input  logic       rst_n,
  output arch_regs_t regs,
  output paddr_t     fetch_addr
);
  localparam arch_regs_t REGS_RST = '{
    ip: IP_RST, cs: CS_RST, ds: DS_RST, es: ES_RST,
    ss: SS_RST, pbase: PBASE_RST, umem: UMEM_RST
  };

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs       <= REGS_RST;
      fetch_addr <= phys_addr(CS_RST, IP_RST);
    end else begin
      regs       <= regs;
      fetch_addr <= phys_addr(regs.cs, regs.ip);
    end
  end
endmodule

// File: rtl/rst_step_trap.sv
// Flag word and single-step trap request.
module rst_step_trap
  import rst_step_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  exec_en,
  input  logic  retire,
  input  logic  iret,
  input  word_t iret_flags,
  input  logic  inta,
  output word_t flags,
  output logic  trap_req,
  output vec_t  trap_vec
);
  logic accept;
  assign accept = exec_en && !trap_req && (retire || iret);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags    <= FLAGS_INIT;
      trap_req <= 1'b0;
      trap_vec <= '0;
    end else if (accept) begin
      // the flag as it stood when this instruction began decides the trap
      trap_req <= flags[TF_BIT];
      trap_vec <= flags[TF_BIT] ? STEP_VEC : '0;
      if (iret) flags <= iret_flags;
    end else if (trap_req && inta) begin
      trap_req      <= 1'b0;
      trap_vec      <= '0;
      flags[TF_BIT] <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_step_ctrl.sv
module rst_step_ctrl
  import rst_step_pkg::*;
#(
  parameter int DELAY_CYC = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        retire_i,
  input  logic        iret_i,
  input  logic [15:0] iret_flags_i,
  input  logic        inta_i,
  output logic        exec_en_o,
  output logic [15:0] flags_o,
  output logic [15:0] ip_o,
  output logic [15:0] cs_o,
  output logic [15:0] ds_o,
  output logic [15:0] es_o,
  output logic [15:0] ss_o,
  output logic [15:0] pbase_o,
  output logic [15:0] umem_o,
  output logic [19:0] fetch_addr_o,
  output logic        trap_req_o,
  output logic [7:0]  trap_vec_o
);
  arch_regs_t regs;

  rst_step_seq #(.DELAY_CYC(DELAY_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec_en (exec_en_o)
  );

  rst_step_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .regs       (regs),
    .fetch_addr (fetch_addr_o)
  );

  rst_step_trap u_trap (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_en    (exec_en_o),
    .retire     (retire_i),
    .iret       (iret_i),
    .iret_flags (iret_flags_i),
    .inta       (inta_i),
    .flags      (flags_o),
    .trap_req   (trap_req_o),
    .trap_vec   (trap_vec_o)
  );

  assign ip_o    = regs.ip;
  assign cs_o    = regs.cs;
  assign ds_o    = regs.ds;
  assign es_o    = regs.es;
  assign ss_o    = regs.ss;
  assign pbase_o = regs.pbase;
  assign umem_o  = regs.umem;
endmodule

// File: rtl/rst_step_ctrl_chk.sv
module rst_step_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        retire_i,
  input logic        iret_i,
  input logic [15:0] iret_flags_i,
  input logic        inta_i,
  input logic        exec_en_o,
  input logic [15:0] flags_o,
  input logic [15:0] ip_o,
  input logic [15:0] cs_o,
  input logic [15:0] ds_o,
  input logic [15:0] es_o,
  input logic [15:0] ss_o,
  input logic [15:0] pbase_o,
  input logic [15:0] umem_o,
  input logic [19:0] fetch_addr_o,
  input logic        trap_req_o,
  input logic [7:0]  trap_vec_o
);
  logic live_q = 1'b0;
  always_ff @(posedge clk) live_q <= 1'b1;

  logic taken;
  assign taken = exec_en_o && !trap_req_o && (retire_i || iret_i);

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!live_q)
    !rst_n |=> (!exec_en_o && !trap_req_o)); // R1
  AST_RST_ARCH: assert property (@(posedge clk) disable iff (!live_q)
    !rst_n |=> (flags_o == 16'hF002 && ip_o == 16'h0000 && cs_o == 16'hFFFF &&
                ds_o == 16'h0000 && es_o == 16'h0000 && ss_o == 16'h0000)); // R2
  AST_RST_PERIPH: assert property (@(posedge clk) disable iff (!live_q)
    !rst_n |=> (pbase_o == 16'h20FF && umem_o == 16'hFFFB)); // R3
  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    $rose(exec_en_o) |-> fetch_addr_o == 20'hFFFF0); // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    exec_en_o |=> exec_en_o); // R5
  AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    !exec_en_o |=> ($stable(flags_o) && !trap_req_o)); // R6
  AST_STEP_FIRE: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    (taken && flags_o[8]) |=> trap_req_o); // R7
  AST_STEP_VEC: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    trap_req_o |-> trap_vec_o == 8'd1); // R7
  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    (trap_req_o && !inta_i) |=> (trap_req_o && $stable(flags_o))); // R8
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    (trap_req_o && inta_i) |=> (!trap_req_o && !flags_o[8])); // R8
  AST_IRET_LOAD: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    (taken && iret_i) |=> flags_o == $past(iret_flags_i)); // R9
  AST_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    (taken && !flags_o[8]) |=> !trap_req_o); // R10
endmodule

bind rst_step_ctrl rst_step_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .iret_i(iret_i),
  .iret_flags_i(iret_flags_i), .inta_i(inta_i), .exec_en_o(exec_en_o),
  .flags_o(flags_o), .ip_o(ip_o), .cs_o(cs_o), .ds_o(ds_o), .es_o(es_o),
  .ss_o(ss_o), .pbase_o(pbase_o), .umem_o(umem_o), .fetch_addr_o(fetch_addr_o),
  .trap_req_o(trap_req_o), .trap_vec_o(trap_vec_o)
);

// File: tb/test_rst_step_ctrl.sv
`timescale 1ns/1ps
module test_rst_step_ctrl;
  localparam int DLY = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire_i = 1'b0;
  logic        iret_i = 1'b0;
  logic [15:0] iret_flags_i = 16'h0000;
  logic        inta_i = 1'b0;
  logic        exec_en_o;
  logic [15:0] flags_o, ip_o, cs_o, ds_o, es_o, ss_o, pbase_o, umem_o;
  logic [19:0] fetch_addr_o;
  logic        trap_req_o;
  logic [7:0]  trap_vec_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rst_step_ctrl #(.DELAY_CYC(DLY)) i_rst_step_ctrl (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .iret_i(iret_i),
    .iret_flags_i(iret_flags_i), .inta_i(inta_i), .exec_en_o(exec_en_o),
    .flags_o(flags_o), .ip_o(ip_o), .cs_o(cs_o), .ds_o(ds_o), .es_o(es_o),
    .ss_o(ss_o), .pbase_o(pbase_o), .umem_o(umem_o), .fetch_addr_o(fetch_addr_o),
    .trap_req_o(trap_req_o), .trap_vec_o(trap_vec_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_retire();
    retire_i = 1'b1; tick(); retire_i = 1'b0;
  endtask

  task automatic do_iret(input logic [15:0] val);
    iret_i = 1'b1; iret_flags_i = val; tick(); iret_i = 1'b0;
  endtask

  task automatic do_ack();
    inta_i = 1'b1; tick(); inta_i = 1'b0;
  endtask

  // release reset and check exec enable at each edge of the window
  task automatic start_up();
    rst_n = 1'b1;
    for (int k = 1; k <= DLY; k++) begin
      tick();
      check($sformatf("R5 exec_en at edge %0d", k), 32'(exec_en_o), 32'(k == DLY));
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    retire_i = 1'b1; iret_i = 1'b1; iret_flags_i = 16'h0100; inta_i = 1'b1;
    tick(); tick();
    retire_i = 1'b0; iret_i = 1'b0; inta_i = 1'b0;
    check("R1 exec_en in reset", 32'(exec_en_o), 32'd0);
    check("R1 trap_req in reset", 32'(trap_req_o), 32'd0);
    check("R2 flags", 32'(flags_o), 32'hF002);
    check("R2 ip", 32'(ip_o), 32'h0000);
    check("R2 cs", 32'(cs_o), 32'hFFFF);
    check("R2 ds/es/ss", {ds_o | es_o, ss_o}, 32'h0);
    check("R3 pbase", 32'(pbase_o), 32'h20FF);
    check("R3 umem", 32'(umem_o), 32'hFFFB);
    check("R4 fetch addr", 32'(fetch_addr_o), 32'hFFFF0);
  endtask

  task automatic t_startup_ignore();
    // strobes held during the whole window must be ignored (R6)
    rst_n = 1'b1;
    retire_i = 1'b1; iret_i = 1'b1; iret_flags_i = 16'h0100;
    for (int k = 1; k <= DLY; k++) begin
      tick();
      if (k == DLY) begin retire_i = 1'b0; iret_i = 1'b0; end
      check($sformatf("R5 exec_en at edge %0d", k), 32'(exec_en_o), 32'(k == DLY));
    end
    check("R6 flags untouched during window", 32'(flags_o), 32'hF002);
    check("R6 no trap during window", 32'(trap_req_o), 32'd0);
    check("R4 fetch addr at enable", 32'(fetch_addr_o), 32'hFFFF0);
    repeat (3) tick();
    check("R5 exec_en stays high", 32'(exec_en_o), 32'd1);
  endtask

  task automatic t_step_basic();
    do_retire();
    check("R10 retire with TF clear", 32'(trap_req_o), 32'd0);
    do_iret(16'h0146);
    check("R9 iret loads flags", 32'(flags_o), 32'h0146);
    check("R9 iret setting TF does not trap", 32'(trap_req_o), 32'd0);
    do_retire();
    check("R7 trap after next instruction", 32'(trap_req_o), 32'd1);
    check("R7 vector", 32'(trap_vec_o), 32'd1);
    do_iret(16'h0000);
    do_retire();
    check("R6 strobes ignored while pending", 32'(flags_o), 32'h0146);
    repeat (3) tick();
    check("R8 request held", 32'(trap_req_o), 32'd1);
    do_ack();
    check("R8 request cleared by ack", 32'(trap_req_o), 32'd0);
    check("R8 ack clears only TF", 32'(flags_o), 32'h0046);
    check("R7 vector idle", 32'(trap_vec_o), 32'd0);
    do_retire();
    check("R10 no trap once TF cleared", 32'(trap_req_o), 32'd0);
    do_ack();
    check("R8 idle ack leaves flags", 32'(flags_o), 32'h0046);
    check("R8 idle ack leaves request", 32'(trap_req_o), 32'd0);
  endtask

  task automatic t_iret_chain();
    do_iret(16'h0100);
    check("R9 first iret no trap", 32'(trap_req_o), 32'd0);
    do_iret(16'h0300);
    check("R9 iret with TF set traps", 32'(trap_req_o), 32'd1);
    check("R9 second iret loads flags", 32'(flags_o), 32'h0300);
    do_ack();
    check("R8 ack clears TF", 32'(flags_o), 32'h0200);
  endtask

  task automatic t_reset_midtrap();
    do_iret(16'h0100);
    do_retire();
    check("R7 trap pending before reset", 32'(trap_req_o), 32'd1);
    rst_n = 1'b0;
    tick();
    check("R1 reset drops trap", 32'(trap_req_o), 32'd0);
    check("R1 reset drops exec_en", 32'(exec_en_o), 32'd0);
    check("R2 reset reloads flags", 32'(flags_o), 32'hF002);
    tick();
    start_up();
    do_retire();
    check("R10 no trap after restart", 32'(trap_req_o), 32'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset_state();
    t_startup_ignore();
    t_step_basic();
    t_iret_chain();
    t_reset_midtrap();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule